// File: doc/BRIEF.md
# Comparator Output Glitch Filter

This block turns the raw, unclocked decision bit of an analog comparator into a clean, registered output. Everything runs on the bus clock. The raw bit and the sample/window input each pass through a two-flop synchronizer before any logic uses them. The sample/window input is only ever read as data and edge-detected. It never clocks a flop.

A sample event comes from one of two sources. In period mode a programmable divider produces it. In external mode it comes from each rising edge of the synchronized sample/window input. The output takes a new value only when a programmed number of consecutive samples all disagree with it. A count of zero bypasses the filter. An optional window gate freezes the output, and clears the filter, while the synchronized window input is low.

In period mode the divider phase restarts when the first disagreement is seen. The delay from input change to output change is therefore fixed. It is count × period + 1 clock edges, counted from the first edge that captures the new raw value. In external mode the first sample can fall anywhere within one sample period after the change.

Top module: `cmp_glitch_filter`

## Requirements
- R1: While `rst_n` is low, the output, the agreement counter, the period counter and all synchronizer stages are zero, so `cmp_out` reads 0 after reset.
- R2: `cmp_raw` and `win_raw` each pass through two synchronizing flops before any other logic uses them.
- R3: In period mode (`ext_sample` = 0), a sample event occurs every `filt_per` clock cycles, and a `filt_per` of 0 behaves as 1. The divider phase restarts while the synchronized bit equals the output, so the first sample after a disagreement starts falls `filt_per` cycles later.
- R4: With `filt_cnt` ≥ 1, `cmp_out` takes the synchronized value at the `filt_cnt`-th consecutive sample that differs from it. In period mode this is exactly `filt_cnt` × `filt_per` + 1 clock edges after the edge that first captures the new `cmp_raw` level.
- R5: Whenever the synchronized bit equals `cmp_out`, the agreement count and the divider phase are cleared. A disagreement that ends before `filt_cnt` samples is rejected, and a later change needs the full count again.
- R6: In external mode (`ext_sample` = 1), a sample event occurs once per rising edge of the synchronized `win_raw`, and the period setting has no effect. A pulse that is high for 4 cycles and low for 4 cycles gives exactly one sample, taken at the third clock edge after the drive.
- R7: With `filt_cnt` = 0, `cmp_out` copies the synchronized bit one cycle later. That is three clock edges after the input is driven.
- R8: With `win_gate_en` = 1 and synchronized `win_raw` low, `cmp_out` holds its value and the filter is cleared. The gate releases two edges after `win_raw` is captured.
- R9: With `filt_cnt` ≥ 1, `cmp_out` changes only at a sample event, and only to the synchronized bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Raw, unclocked comparator decision |
| win_raw | input | 1 | Asynchronous sample/window input |
| ext_sample | input | 1 | 1: sample on window rising edges; 0: sample from period divider |
| win_gate_en | input | 1 | 1: hold output while window input is low |
| filt_cnt | input | CNT_W | Consecutive agreeing samples needed (0 = bypass) |
| filt_per | input | PER_W | Divider period in clock cycles (0 treated as 1) |
| cmp_out | output | 1 | Filtered comparator output |

## Verification
The assertions assume that `filt_cnt`, `filt_per`, `ext_sample` and `win_gate_en` change only while the filter is idle. Idle means the synchronized bit equals the output. The period-spacing property also assumes `filt_per` is held steady. The stimulus changes the configuration only after the output has settled on the raw level. It drives the external input only with pulses that stay high and low for four cycles each. Every input changes at the falling clock edge, so each synchronizer stage captures a clean level.

// File: rtl/cgf_pkg.sv
package cgf_pkg;

  // Source of filter sample events.
  typedef enum logic {
    SRC_PERIOD   = 1'b0,
    SRC_EXTERNAL = 1'b1
  } src_e;

  // Last divider count for a programmed period; a period of 0 acts as 1.
  function automatic int unsigned eff_last(int unsigned per);
    return (per == 0) ? 0 : per - 1;
  endfunction

  // True when one more agreeing sample reaches the programmed quota.
  function automatic logic quota_met(int unsigned agreed, int unsigned target);
    return (agreed + 1) >= target;
  endfunction

endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cgf_sample_gen.sv
module cgf_sample_gen
  import cgf_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic [PER_W-1:0] per,
  input  logic             restart,
  input  logic             win_s,
  output logic             samp_evt,
  output logic             win_rise
);
  logic             win_d;
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] per_last;
  logic             per_tick;

  assign per_last = PER_W'(eff_last(32'(per)));
  assign per_tick = (per_cnt >= per_last);
  assign win_rise = win_s & ~win_d;

  always_comb begin
    case (src)
      SRC_EXTERNAL: samp_evt = win_rise;
      default:      samp_evt = per_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_d <= 1'b0;
    else        win_d <= win_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        per_cnt <= '0;
    else if (restart)  per_cnt <= '0;
    else if (per_tick) per_cnt <= '0;
    else               per_cnt <= per_cnt + 1'b1;
  end
endmodule

// File: rtl/cgf_agree.sv
module cgf_agree
  import cgf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_s,
  input  logic             samp_evt,
  input  logic             hold,
  input  logic [CNT_W-1:0] filt_cnt,
  output logic             restart,
  output logic             cmp_out
);
  logic [CNT_W-1:0] agree_cnt;
  logic             quota;

  assign restart = hold | (cmp_s == cmp_out);
  assign quota   = quota_met(32'(agree_cnt), 32'(filt_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_out   <= 1'b0;
      agree_cnt <= '0;
    end else if (hold) begin
      agree_cnt <= '0;
    end else if (filt_cnt == '0) begin
      cmp_out   <= cmp_s;
      agree_cnt <= '0;
    end else if (cmp_s == cmp_out) begin
      agree_cnt <= '0;
    end else if (samp_evt) begin
      if (quota) begin
        cmp_out   <= cmp_s;
        agree_cnt <= '0;
      end else begin
        agree_cnt <= agree_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter
  import cgf_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int PER_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             win_raw,
  input  logic             ext_sample,
  input  logic             win_gate_en,
  input  logic [CNT_W-1:0] filt_cnt,
  input  logic [PER_W-1:0] filt_per,
  output logic             cmp_out
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              cmp_s;
  logic              win_s;
  logic              win_rise;
  logic              samp_evt;
  logic              restart;
  logic              hold;
  src_e              src;

  cgf_sync #(.W(SYNC_W), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({win_raw, cmp_raw}),
    .q     (sync_q)
  );

  assign cmp_s = sync_q[0];
  assign win_s = sync_q[1];
  assign src   = ext_sample ? SRC_EXTERNAL : SRC_PERIOD;
  assign hold  = win_gate_en & ~win_s;

  cgf_sample_gen #(.PER_W(PER_W)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .per      (filt_per),
    .restart  (restart),
    .win_s    (win_s),
    .samp_evt (samp_evt),
    .win_rise (win_rise)
  );

  cgf_agree #(.CNT_W(CNT_W)) u_agree (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_s    (cmp_s),
    .samp_evt (samp_evt),
    .hold     (hold),
    .filt_cnt (filt_cnt),
    .restart  (restart),
    .cmp_out  (cmp_out)
  );
endmodule

// File: rtl/cgf_checker.sv
module cgf_checker #(
  parameter int CNT_W = 4,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_sample,
  input logic             win_gate_en,
  input logic [CNT_W-1:0] filt_cnt,
  input logic [PER_W-1:0] filt_per,
  input logic             win_s,
  input logic             win_rise,
  input logic             samp_evt,
  input logic             cmp_s,
  input logic             cmp_out
);
  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_gate_en && !win_s) |=> $stable(cmp_out));

  // R9
  move_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_cnt != '0 && !samp_evt) |=> $stable(cmp_out));

  // R9
  take_sync_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_out != $past(cmp_out)) |-> (cmp_out == $past(cmp_s)));

  // R7
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_cnt == '0 && !(win_gate_en && !win_s)) |=> (cmp_out == $past(cmp_s)));

  // R6
  ext_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sample && samp_evt) |=> !samp_evt);

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rise |=> !win_rise);

  // R3
  period_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sample && samp_evt && filt_per > 1 && $stable(filt_per)) |=> !samp_evt);
endmodule

bind cmp_glitch_filter cgf_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_sample  (ext_sample),
  .win_gate_en (win_gate_en),
  .filt_cnt    (filt_cnt),
  .filt_per    (filt_per),
  .win_s       (win_s),
  .win_rise    (win_rise),
  .samp_evt    (samp_evt),
  .cmp_s       (cmp_s),
  .cmp_out     (cmp_out)
);

// File: tb/cmp_glitch_filter_test.sv
module cmp_glitch_filter_test;
  localparam int CNT_W = 4;
  localparam int PER_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmp_raw = 1'b0;
  logic             win_raw = 1'b0;
  logic             ext_sample = 1'b0;
  logic             win_gate_en = 1'b0;
  logic [CNT_W-1:0] filt_cnt = 4'd3;
  logic [PER_W-1:0] filt_per = 8'd4;
  logic             cmp_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  cmp_glitch_filter #(.CNT_W(CNT_W), .PER_W(PER_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_raw     (cmp_raw),
    .win_raw     (win_raw),
    .ext_sample  (ext_sample),
    .win_gate_en (win_gate_en),
    .filt_cnt    (filt_cnt),
    .filt_per    (filt_per),
    .cmp_out     (cmp_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void expect_at(int at, logic val, string tag);
    exp_t e;
    e.at  = at;
    e.val = val;
    e.tag = tag;
    sb.push_back(e);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops expectations whose cycle has come.
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      checks++;
      if (e.at != cyc || cmp_out !== e.val) begin
        errors++;
        $display("FAIL %s: cycle %0d cmp_out=%b expected %b (due cycle %0d)",
                 e.tag, cyc, cmp_out, e.val, e.at);
      end
    end
  end

  // Driver
  initial begin
    int c;
    idle(3);
    checks++;  // R1 reset state
    if (cmp_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: cmp_out=%b expected 0 in reset", cmp_out);
    end
    rst_n = 1'b1;
    idle(4);

    // R4 R9: period mode, count 3, period 4 -> 13 edges after capture edge
    c = cyc; cmp_raw = 1'b1;
    expect_at(c + 13, 1'b0, "R4 R9 before");
    expect_at(c + 14, 1'b1, "R4 R9 after");
    idle(20);

    // R4: count 2, period 5, falling change
    filt_cnt = 4'd2; filt_per = 8'd5;
    c = cyc; cmp_raw = 1'b0;
    expect_at(c + 11, 1'b1, "R4 before");
    expect_at(c + 12, 1'b0, "R4 after");
    idle(20);

    // R3: period 0 acts as 1, count 4
    filt_cnt = 4'd4; filt_per = 8'd0;
    c = cyc; cmp_raw = 1'b1;
    expect_at(c + 5, 1'b0, "R3 before");
    expect_at(c + 6, 1'b1, "R3 after");
    idle(15);

    // R5: 5-cycle glitch rejected, then full count needed again
    filt_cnt = 4'd3; filt_per = 8'd4;
    c = cyc; cmp_raw = 1'b0;
    expect_at(c + 25, 1'b1, "R5 glitch rejected");
    idle(5); cmp_raw = 1'b1;
    idle(30);
    c = cyc; cmp_raw = 1'b0;
    expect_at(c + 13, 1'b1, "R5 before");
    expect_at(c + 14, 1'b0, "R5 after");
    idle(20);

    // R7 R2: bypass, three edges from drive
    filt_cnt = 4'd0;
    c = cyc; cmp_raw = 1'b1;
    expect_at(c + 2, 1'b0, "R7 R2 before");
    expect_at(c + 3, 1'b1, "R7 R2 after");
    idle(10);

    // R6: external mode, period ignored, three pulses
    filt_cnt = 4'd3; filt_per = 8'd1; ext_sample = 1'b1;
    c = cyc; cmp_raw = 1'b0;
    expect_at(c + 12, 1'b1, "R6 no pulses");
    idle(12);
    c = cyc;
    expect_at(c + 18, 1'b1, "R6 before");
    expect_at(c + 19, 1'b0, "R6 after");
    for (int i = 0; i < 3; i++) begin
      win_raw = 1'b1; idle(4);
      win_raw = 1'b0; idle(4);
    end
    idle(6);

    // R8 R2: window gate holds, release after two sync edges
    ext_sample = 1'b0; win_gate_en = 1'b1; filt_cnt = 4'd1; filt_per = 8'd1;
    c = cyc; cmp_raw = 1'b1;
    expect_at(c + 10, 1'b0, "R8 held");
    idle(10);
    c = cyc; win_raw = 1'b1;
    expect_at(c + 2, 1'b0, "R8 R2 before release");
    expect_at(c + 3, 1'b1, "R8 R2 after release");
    idle(8);

    wait (sb.size() == 0);
    idle(2);
    report();
  end

  // Watchdog
  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, pending=%0d expected 0", sb.size());
    report();
  end
endmodule